// File: doc/BRIEF.md
# Shadowed Register Commit Controller

This block holds a small bank of configuration words for a display datapath in two copies. Software writes a shadow copy through a simple register port. The active copy drives the datapath and changes only at a vertical blanking strobe, so a frame never starts on a half-written configuration.

The control word at address 0 has two bits. A load-request bit arms a single transfer. An autoload-off bit selects the update mode. With autoload off, the shadow words move to the active set only at the first blanking strobe after a request. The request bit then clears itself, so software can poll it to see when the transfer is done. With autoload on, every blanking strobe copies the shadow into the active set. All words reset to zero, so read-modify-write sequences start from known values.

Top module: `shadow_commit_top`

## Requirements
- R1: After reset, every readable address returns zero and the whole active bus is zero.
- R2: A write to address k (1..7) updates shadow word k. A read of address k returns the shadow value, even while the active copy still holds an older value.
- R3: Control word at address 0: bit 0 is the load request and bit 1 is autoload-off. Both read back in place, and all other bits read as zero.
- R4: With autoload-off set and no request pending, a vblank strobe leaves the active bus unchanged.
- R5: With a request pending, the next vblank strobe copies every shadow word into the active set. The request bit clears at that same clock edge.
- R6: The request bit reads as 1 from the cycle after it is written until the transfer edge. Without a vblank it stays set.
- R7: If a request is written in the same cycle as a vblank strobe and none was pending, no transfer happens on that strobe. The transfer happens at the next strobe.
- R8: Shadow writes made while a request is pending are included in that pending transfer.
- R9: With autoload-off clear, every vblank strobe copies the shadow into the active set, with no request needed.
- R10: Writing 0 to the request bit while a request is pending does not cancel it.
- R11: Shadow word k appears on active bus bits [(k-1)*32 +: 32].
- R12: A shadow write in the same cycle as a transfer does not reach the active set on that transfer. The active word takes the value held before the write, and the new value stays in the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe |
| cfg_waddr | input | 3 | Word address of write |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 3 | Word address of read |
| cfg_rdata | output | 32 | Read data (combinational; shadow or control word) |
| vblank | input | 1 | One-cycle vertical blanking strobe |
| active_cfg | output | 224 | Active configuration words 1..7, packed |

## Verification
A missed or extra transfer shows on the active bus on the clock edge of the vblank strobe itself. The bench compares the whole bus against its model after every cycle, so such a fault is caught within one cycle. A wrong request bit shows on the next read of address 0, which the bench polls around each directed strobe. A transfer that copies from the wrong copy or the wrong slot shows as a mismatched word at a specific bit position of the active bus.

// File: rtl/shadow_commit_pkg.sv
package shadow_commit_pkg;

  localparam int unsigned LOAD_BIT = 0;
  localparam int unsigned AUTO_OFF_BIT = 1;

  typedef struct packed {
    logic auto_off;
    logic pending;
  } ctrl_state_t;

  // Pack the control state into a readable word; unused bits are zero.
  function automatic logic [31:0] ctrl_word(input ctrl_state_t st);
    logic [31:0] w;
    w = '0;
    w[LOAD_BIT] = st.pending;
    w[AUTO_OFF_BIT] = st.auto_off;
    return w;
  endfunction

  // A transfer happens on a blank if armed, or always when autoload is on.
  function automatic logic copy_due(input logic blank, input ctrl_state_t st);
    return blank & (st.pending | ~st.auto_off);
  endfunction

  // Next request state: a blank retires an armed request, a new write arms one.
  function automatic logic next_pending(input logic blank, input logic pend,
                                        input logic arm);
    return (pend & ~blank) | arm;
  endfunction

endpackage

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl
  import shadow_commit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic        wr_load,
  input  logic        wr_auto_off,
  input  logic        vblank,
  output ctrl_state_t state_q,
  output logic        copy_evt
);

  logic arm_req;
  ctrl_state_t state_d;

  assign arm_req  = ctrl_we & wr_load;
  assign copy_evt = copy_due(vblank, state_q);

  always_comb begin
    state_d = state_q;
    state_d.pending = next_pending(vblank, state_q.pending, arm_req);
    if (ctrl_we) state_d.auto_off = wr_auto_off;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q.pending && !vblank) |=> state_q.pending); // R6

  AST_PEND_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q.pending && vblank && !arm_req) |=> !state_q.pending); // R5

  AST_SAME_CYCLE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && vblank && !state_q.pending) |=> state_q.pending); // R7

  AST_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q.pending && ctrl_we && !wr_load && !vblank) |=> state_q.pending); // R10

endmodule

// File: rtl/shadow_commit_bank.sv
module shadow_commit_bank #(
  parameter int unsigned SLOTS = 7,
  parameter int unsigned DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS-1:0]    load_en,
  input  logic [SLOTS*DW-1:0] din,
  output logic [SLOTS*DW-1:0] dout
);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          word_q <= '0;
      else if (load_en[k]) word_q <= din[k*DW +: DW];
    end
    assign dout[k*DW +: DW] = word_q;
  end

endmodule

// File: rtl/shadow_commit_top.sv
module shadow_commit_top
  import shadow_commit_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DW       = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned SLOTS   = NUM_REGS - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_waddr,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic [AW-1:0]       cfg_raddr,
  output logic [DW-1:0]       cfg_rdata,
  input  logic                vblank,
  output logic [SLOTS*DW-1:0] active_cfg
);

  ctrl_state_t         ctrl_q;
  logic                copy_evt;
  logic                ctrl_we;
  logic [SLOTS-1:0]    shadow_en;
  logic [SLOTS*DW-1:0] shadow_flat;
  logic [SLOTS*DW-1:0] shadow_din;

  assign ctrl_we = cfg_we && (cfg_waddr == '0);

  for (genvar k = 0; k < SLOTS; k++) begin : g_dec
    assign shadow_en[k] = cfg_we && (cfg_waddr == AW'(k + 1));
    assign shadow_din[k*DW +: DW] = cfg_wdata;
  end

  shadow_commit_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .wr_load     (cfg_wdata[LOAD_BIT]),
    .wr_auto_off (cfg_wdata[AUTO_OFF_BIT]),
    .vblank      (vblank),
    .state_q     (ctrl_q),
    .copy_evt    (copy_evt)
  );

  shadow_commit_bank #(.SLOTS(SLOTS), .DW(DW)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (shadow_en),
    .din     (shadow_din),
    .dout    (shadow_flat)
  );

  shadow_commit_bank #(.SLOTS(SLOTS), .DW(DW)) u_active (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en ({SLOTS{copy_evt}}),
    .din     (shadow_flat),
    .dout    (active_cfg)
  );

  always_comb begin
    cfg_rdata = ctrl_word(ctrl_q);
    for (int k = 0; k < SLOTS; k++)
      if (cfg_raddr == AW'(k + 1)) cfg_rdata = shadow_flat[k*DW +: DW];
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_evt |=> $stable(active_cfg)); // R4

  AST_COPY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |=> (active_cfg == $past(shadow_flat))); // R12

  AST_AUTO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !ctrl_q.auto_off) |-> copy_evt); // R9

  AST_ARMED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && ctrl_q.pending) |-> copy_evt); // R5

endmodule

// File: tb/sim_shadow_commit_top.sv
`timescale 1ns/1ps
module sim_shadow_commit_top;

  localparam int NR = 8;
  localparam int DW = 32;
  localparam int SL = NR - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_waddr = 0;
  logic [DW-1:0] cfg_wdata = 0;
  logic [2:0] cfg_raddr = 0;
  logic [DW-1:0] cfg_rdata;
  logic vblank = 0;
  logic [SL*DW-1:0] active_cfg;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] m_sh [NR];
  logic [DW-1:0] m_act [NR];
  logic m_pend, m_aoff;

  always #2 clk = ~clk;

  shadow_commit_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .vblank(vblank), .active_cfg(active_cfg)
  );

  function automatic logic [SL*DW-1:0] pack_act();
    logic [SL*DW-1:0] v;
    for (int k = 1; k < NR; k++) v[(k-1)*DW +: DW] = m_act[k];
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_read(input int a);
    if (a == 0) return {30'd0, m_aoff, m_pend};
    return m_sh[a];
  endfunction

  task automatic chk(input string tag, input logic [SL*DW-1:0] act,
                     input logic [SL*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_read(input string tag, input int a);
    cfg_raddr = 3'(a);
    #1;
    chk(tag, {192'd0, cfg_rdata}, {192'd0, exp_read(a)});
  endtask

  task automatic chk_bus(input string tag);
    chk(tag, active_cfg, pack_act());
  endtask

  // One clock cycle: drive at negedge, model the edge, return at next negedge.
  task automatic step(input logic we, input int a, input logic [DW-1:0] d,
                      input logic vb);
    logic copy;
    cfg_we = we; cfg_waddr = 3'(a); cfg_wdata = d; vblank = vb;
    @(posedge clk);
    copy = vb && (m_pend || !m_aoff);
    if (copy) for (int k = 1; k < NR; k++) m_act[k] = m_sh[k];
    m_pend = (m_pend && !vb) || (we && a == 0 && d[0]);
    if (we) begin
      if (a == 0) m_aoff = d[1];
      else m_sh[a] = d;
    end
    @(negedge clk);
    cfg_we = 0; vblank = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < NR; k++) begin m_sh[k] = 0; m_act[k] = 0; end
    m_pend = 0; m_aoff = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < NR; a++) chk_read("R1 reset read", a);
    chk_bus("R1 reset bus");

    // R2, R4: explicit mode, shadow write not visible on active
    step(1, 0, 32'h2, 0);
    chk_read("R3 ctrl autoload-off", 0);
    step(1, 3, 32'hA5A5_0003, 0);
    chk_read("R2 shadow readback", 3);
    chk_bus("R2 active unchanged");
    step(0, 0, 0, 1);
    chk_bus("R4 no transfer without request");

    // R3, R6, R8, R10, R5, R11
    step(1, 0, 32'hFFFF_FFFF, 0);
    chk_read("R3 ctrl upper bits zero", 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk_read("R6 request held", 0);
    step(1, 5, 32'hBEEF_0005, 0);
    step(1, 0, 32'h2, 0);
    chk_read("R10 request not cancelled", 0);
    step(0, 0, 0, 1);
    chk_bus("R5 transfer on vblank");
    chk("R8 pending write included", {192'd0, active_cfg[4*DW +: DW]},
        {192'd0, 32'hBEEF_0005});
    chk("R11 slot position", {192'd0, active_cfg[2*DW +: DW]},
        {192'd0, 32'hA5A5_0003});
    chk_read("R5 request cleared", 0);

    // R7 request on the vblank cycle waits for next strobe
    step(1, 2, 32'h1234_0002, 0);
    step(1, 0, 32'h3, 1);
    chk_bus("R7 no transfer on same-cycle strobe");
    chk_read("R7 request pending", 0);
    step(0, 0, 0, 1);
    chk_bus("R7 transfer on following strobe");

    // R12 write on the transfer cycle
    step(1, 1, 32'h0000_1111, 0);
    step(1, 0, 32'h3, 0);
    step(1, 1, 32'h2222_0000, 1);
    chk("R12 active has prior value", {192'd0, active_cfg[0 +: DW]},
        {192'd0, 32'h0000_1111});
    chk_read("R12 shadow has new value", 1);

    // R9 autoload
    step(1, 0, 32'h0, 0);
    step(1, 7, 32'hD00D_0007, 0);
    step(0, 0, 0, 1);
    chk_bus("R9 autoload copy");
    step(1, 6, 32'h0606_0606, 1);
    step(0, 0, 0, 1);
    chk_bus("R9 autoload second copy");

    // Random mix against the model
    for (int i = 0; i < 600; i++) begin
      logic we, vb;
      int a;
      logic [DW-1:0] d;
      we = ($urandom % 3) != 0;
      a  = (($urandom % 4) == 0) ? 0 : int'($urandom % NR);
      d  = $urandom;
      vb = ($urandom % 5) == 0;
      step(we, a, d, vb);
      chk_bus("R5 R9 random active bus");
      if (i % 7 == 0) chk_read("R2 R6 random read", int'($urandom % NR));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule